// File: doc/BRIEF.md
# Cubic-Weighted Net Coefficient Builder

This block prepares the coefficients of a single time-varying FIR filter for one output instant of an asynchronous sample-rate converter. A bank of fractional-delay subfilters sits in a preloaded memory outside the block. For each output sample the caller supplies a subfilter index `k` and a blend position `tc` between neighbouring subfilter phases, then pulses a start strobe. The block turns `tc` into four cubic (Lagrange) blend weights and combines four adjacent subfilters, `k` through `k+3`, tap by tap into one net coefficient per tap.

The cubic interpolation acts on the coefficients, not on filter outputs. The result is one filter per output instant, and every channel that shares those sample times can reuse it. The net coefficients leave as a write stream (strobe, tap address, value) into the small coefficient buffer of the multiply-accumulate engine. A done pulse marks the last tap. The memory holds `M+3` subfilters of `L` taps each. The three top subfilters are the first three delayed by one sample, with a zero first tap, so `k` may take any value below `M` without wrap logic.

Top module: `nfb_net_builder`

## Requirements
- R1: With `t = tc_i / 2^TW`, the block computes four Q1.30 weights: wa = (−t³+3t²−2t)/6, wb = (t³−2t²−t+2)/2, wc = (−t³+t²+2t)/2, wd = (t³−t)/6. Each weight is the exact value times 2^30, rounded to the nearest integer with ties away from zero. The coefficient for tap i is `floor((wa·h[k][i] + wb·h[k+1][i] + wc·h[k+2][i] + wd·h[k+3][i] + 2^29) / 2^30)`, where `h` are signed CW-bit table words. It appears on `coef_o` as a signed CW+2-bit value.
- R2: Subfilter s, tap i is stored at table address `s·L + i`. Read port p (0..3) fetches subfilter `k+p`. For k = M−1 this reaches subfilter M+2 at the top of the table.
- R3: When a start is accepted on a rising edge, the write strobe for tap i is high during the cycle that begins i+2 edges later. The strobe is low again in the cycle after the last tap.
- R4: `done_o` is high for exactly one cycle: the cycle in which tap L−1 is written.
- R5: The four weights sum to one within 2 LSB of Q1.30. If all four subfilters hold the same value v at a tap, that tap's coefficient equals v for every `tc_i`.
- R6: With `tc_i = 0`, every net coefficient equals tap i of subfilter k+1 exactly.
- R7: A start strobe that arrives while a run is still issuing reads is ignored. The running output sequence is unchanged.
- R8: While reset is high, `coef_we_o`, `done_o` and `tbl_rd_o` are low.
- R9: Each accepted start raises `tbl_rd_o` for exactly L consecutive cycles. The memory answers one cycle after each read.
- R10: Taps are written in ascending order 0..L−1 in consecutive cycles, with `coef_addr_o` holding the tap index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin building a net filter |
| k_i | input | $clog2(M) | Index of the first of four subfilters, below M |
| tc_i | input | TW | Unsigned fractional blend position |
| tbl_rd_o | output | 1 | Table read enable |
| tbl_addr_o | output | 4 × $clog2((M+3)·L) | Table addresses, one per read port |
| tbl_q_i | input | 4 × CW | Table words, one cycle after the read |
| coef_we_o | output | 1 | Coefficient buffer write strobe |
| coef_addr_o | output | $clog2(L) | Tap index being written |
| coef_o | output | CW+2 | Signed net coefficient |
| done_o | output | 1 | Pulses with the last tap |

## Verification
The assertions assume that `k_i` is below M whenever a start is accepted, that `TW` is at most 10 so the weight arithmetic fits its scaling, and that the memory answers each read on the next edge. The bench keeps `k_i` within range. It models the table as a one-cycle synchronous memory filled with a synthetic prototype whose top three subfilters are delayed copies of the first three. It then sweeps every `tc_i` code against every legal `k_i`, and adds constant-valued and full-scale tables that probe the weight sum and the output range.

// File: rtl/nfb_pkg.sv
package nfb_pkg;

    localparam int WFRAC = 30;          // weight fraction bits (Q1.30)
    localparam int WBITS = 32;          // weight word width
    localparam int NBITS = 40;          // scratch width for weight numerators
    localparam int NPORT = 4;           // subfilters blended per tap

    typedef struct packed {
        logic signed [WBITS-1:0] a;
        logic signed [WBITS-1:0] b;
        logic signed [WBITS-1:0] c;
        logic signed [WBITS-1:0] d;
    } wgt_t;

    localparam wgt_t WGT_UNITY = '{a: '0, b: 32'sh4000_0000, c: '0, d: '0};

    // nearest-integer divide by 6, ties away from zero
    function automatic logic signed [WBITS-1:0] rdiv6(input logic signed [NBITS-1:0] n);
        logic [NBITS-1:0] mag;
        logic [NBITS-1:0] q;
        mag = n[NBITS-1] ? NBITS'(-n) : NBITS'(n);
        q   = (mag + NBITS'(3)) / NBITS'(6);
        return n[NBITS-1] ? -WBITS'(q) : WBITS'(q);
    endfunction

    // nearest-integer divide by 2, ties away from zero
    function automatic logic signed [WBITS-1:0] rdiv2(input logic signed [NBITS-1:0] n);
        logic [NBITS-1:0] mag;
        logic [NBITS-1:0] q;
        mag = n[NBITS-1] ? NBITS'(-n) : NBITS'(n);
        q   = (mag + NBITS'(1)) >> 1;
        return n[NBITS-1] ? -WBITS'(q) : WBITS'(q);
    endfunction

endpackage

// File: rtl/nfb_weight_gen.sv
module nfb_weight_gen
    import nfb_pkg::*;
#(
    parameter int TW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_i,
    input  logic [TW-1:0] tc_i,
    output wgt_t          wgt_o
);
    localparam int SH = WFRAC - 3 * TW;   // requires TW <= 10

    logic signed [NBITS-1:0] t1, t2, t3;
    logic signed [NBITS-1:0] na, nb, nc, nd;
    wgt_t wgt_n, wgt_q;

    always_comb begin
        t1 = {{(NBITS-TW){1'b0}}, tc_i};
        t2 = t1 * t1;
        t3 = t2 * t1;
        // numerators scaled by 2^(3*TW)
        na = -t3 + 40'sd3 * (t2 <<< TW) - 40'sd2 * (t1 <<< (2 * TW));
        nb = t3 - 40'sd2 * (t2 <<< TW) - (t1 <<< (2 * TW)) + (40'sd2 <<< (3 * TW));
        nc = -t3 + (t2 <<< TW) + 40'sd2 * (t1 <<< (2 * TW));
        nd = t3 - (t1 <<< (2 * TW));
        wgt_n.a = rdiv6(na <<< SH);
        wgt_n.b = rdiv2(nb <<< SH);
        wgt_n.c = rdiv2(nc <<< SH);
        wgt_n.d = rdiv6(nd <<< SH);
    end

    always_ff @(posedge clk) begin
        if (rst)         wgt_q <= WGT_UNITY;
        else if (load_i) wgt_q <= wgt_n;
    end

    assign wgt_o = wgt_q;
endmodule

// File: rtl/nfb_tap_seq.sv
module nfb_tap_seq
    import nfb_pkg::*;
#(
    parameter int M = 4,
    parameter int L = 8
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic                                   start_i,
    input  logic [$clog2(M)-1:0]                   k_i,
    output logic                                   accept_o,
    output logic                                   rd_o,
    output logic [NPORT-1:0][$clog2((M+3)*L)-1:0]  addr_o,
    output logic [$clog2(L)-1:0]                   tap_o,
    output logic                                   last_o
);
    localparam int KW = $clog2(M);
    localparam int IW = $clog2(L);
    localparam int AW = $clog2((M + 3) * L);
    localparam logic [IW-1:0] TAP_END = IW'(L - 1);

    logic          busy_q;
    logic [IW-1:0] cnt_q;
    logic [KW-1:0] k_q;

    assign accept_o = start_i && !busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            k_q    <= '0;
        end else if (accept_o) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
            k_q    <= k_i;
        end else if (busy_q) begin
            if (cnt_q == TAP_END) begin
                busy_q <= 1'b0;
                cnt_q  <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        assign addr_o[p] = AW'((int'(k_q) + p) * L + int'(cnt_q));
    end

    assign rd_o   = busy_q;
    assign tap_o  = cnt_q;
    assign last_o = busy_q && (cnt_q == TAP_END);
endmodule

// File: rtl/nfb_blend.sv
module nfb_blend
    import nfb_pkg::*;
#(
    parameter int L  = 8,
    parameter int CW = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         vld_i,
    input  logic [$clog2(L)-1:0]         tap_i,
    input  logic                         last_i,
    input  wgt_t                         wgt_i,
    input  logic [NPORT-1:0][CW-1:0]     q_i,
    output logic                         we_o,
    output logic [$clog2(L)-1:0]         addr_o,
    output logic [CW+1:0]                coef_o,
    output logic                         done_o
);
    localparam int IW = $clog2(L);
    localparam int OW = CW + 2;
    localparam int PW = WBITS + CW;
    localparam int SW = PW + 2;
    localparam logic signed [SW-1:0] RND = SW'(1) <<< (WFRAC - 1);

    // control aligned with the memory answer
    logic          vld_d, last_d;
    logic [IW-1:0] tap_d;

    logic signed [WBITS-1:0] wv   [NPORT];
    logic signed [PW-1:0]    prod [NPORT];
    logic signed [SW-1:0]    acc;

    assign wv[0] = wgt_i.a;
    assign wv[1] = wgt_i.b;
    assign wv[2] = wgt_i.c;
    assign wv[3] = wgt_i.d;

    for (genvar p = 0; p < NPORT; p++) begin : g_mul
        assign prod[p] = PW'(wv[p]) * PW'($signed(q_i[p]));
    end

    always_comb begin
        acc = '0;
        for (int p = 0; p < NPORT; p++) acc = acc + SW'(prod[p]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_d  <= 1'b0;
            last_d <= 1'b0;
            tap_d  <= '0;
            we_o   <= 1'b0;
            done_o <= 1'b0;
            addr_o <= '0;
            coef_o <= '0;
        end else begin
            vld_d  <= vld_i;
            last_d <= last_i;
            tap_d  <= tap_i;
            we_o   <= vld_d;
            done_o <= vld_d && last_d;
            if (vld_d) begin
                addr_o <= tap_d;
                coef_o <= OW'((acc + RND) >>> WFRAC);
            end
        end
    end
endmodule

// File: rtl/nfb_net_builder.sv
module nfb_net_builder
    import nfb_pkg::*;
#(
    parameter int M  = 4,
    parameter int L  = 8,
    parameter int CW = 16,
    parameter int TW = 6
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic                                   start_i,
    input  logic [$clog2(M)-1:0]                   k_i,
    input  logic [TW-1:0]                          tc_i,
    output logic                                   tbl_rd_o,
    output logic [NPORT-1:0][$clog2((M+3)*L)-1:0]  tbl_addr_o,
    input  logic [NPORT-1:0][CW-1:0]               tbl_q_i,
    output logic                                   coef_we_o,
    output logic [$clog2(L)-1:0]                   coef_addr_o,
    output logic [CW+1:0]                          coef_o,
    output logic                                   done_o
);
    localparam int IW = $clog2(L);

    logic          accept;
    logic [IW-1:0] tap_issue;
    logic          last_issue;
    wgt_t          wgt_q;

    nfb_weight_gen #(.TW(TW)) u_wgt (
        .clk    (clk),
        .rst    (rst),
        .load_i (accept),
        .tc_i   (tc_i),
        .wgt_o  (wgt_q)
    );

    nfb_tap_seq #(.M(M), .L(L)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start_i),
        .k_i      (k_i),
        .accept_o (accept),
        .rd_o     (tbl_rd_o),
        .addr_o   (tbl_addr_o),
        .tap_o    (tap_issue),
        .last_o   (last_issue)
    );

    nfb_blend #(.L(L), .CW(CW)) u_blend (
        .clk    (clk),
        .rst    (rst),
        .vld_i  (tbl_rd_o),
        .tap_i  (tap_issue),
        .last_i (last_issue),
        .wgt_i  (wgt_q),
        .q_i    (tbl_q_i),
        .we_o   (coef_we_o),
        .addr_o (coef_addr_o),
        .coef_o (coef_o),
        .done_o (done_o)
    );
endmodule

// File: rtl/nfb_checker.sv
module nfb_checker
    import nfb_pkg::*;
#(
    parameter int M  = 4,
    parameter int L  = 8,
    parameter int CW = 16,
    parameter int TW = 6
) (
    input logic                                   clk,
    input logic                                   rst,
    input logic                                   tbl_rd_o,
    input logic [NPORT-1:0][$clog2((M+3)*L)-1:0]  tbl_addr_o,
    input logic                                   coef_we_o,
    input logic [$clog2(L)-1:0]                   coef_addr_o,
    input logic                                   done_o,
    input wgt_t                                   wgt
);
    localparam int IW = $clog2(L);
    localparam int AW = $clog2((M + 3) * L);
    localparam int CNW = $clog2(L + 1) + 1;
    localparam logic signed [WBITS+1:0] ONE = 34'sd1 <<< WFRAC;

    logic signed [WBITS+1:0] wsum;
    logic [CNW-1:0]          rd_run;

    assign wsum = (WBITS+2)'(wgt.a) + (WBITS+2)'(wgt.b)
                + (WBITS+2)'(wgt.c) + (WBITS+2)'(wgt.d);

    always_ff @(posedge clk) begin
        if (rst)           rd_run <= '0;
        else if (tbl_rd_o) rd_run <= rd_run + 1'b1;
        else               rd_run <= '0;
    end

    assert_wsum_R5: assert property (@(posedge clk) disable iff (rst)
        (wsum >= ONE - 2) && (wsum <= ONE + 2));

    assert_done_last_R4: assert property (@(posedge clk) disable iff (rst)
        done_o |-> coef_we_o && (coef_addr_o == IW'(L - 1)));

    assert_done_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    assert_first_tap_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(coef_we_o) |-> (coef_addr_o == '0));

    assert_tap_step_R10: assert property (@(posedge clk) disable iff (rst)
        (coef_we_o && coef_addr_o != IW'(L - 1))
            |=> coef_we_o && (coef_addr_o == $past(coef_addr_o) + 1'b1));

    assert_rd_to_we_R3: assert property (@(posedge clk) disable iff (rst)
        tbl_rd_o |-> ##2 coef_we_o);

    assert_rd_len_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(tbl_rd_o) |-> (rd_run == CNW'(L)));

    assert_rd_cap_R9: assert property (@(posedge clk) disable iff (rst)
        tbl_rd_o |-> (rd_run < CNW'(L)));

    assert_addr_step_R2: assert property (@(posedge clk) disable iff (rst)
        (tbl_rd_o && $past(tbl_rd_o) && rd_run != '0)
            |-> (tbl_addr_o[0] == $past(tbl_addr_o[0]) + AW'(1)));
endmodule

bind nfb_net_builder nfb_checker #(.M(M), .L(L), .CW(CW), .TW(TW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .tbl_rd_o    (tbl_rd_o),
    .tbl_addr_o  (tbl_addr_o),
    .coef_we_o   (coef_we_o),
    .coef_addr_o (coef_addr_o),
    .done_o      (done_o),
    .wgt         (wgt_q)
);

// File: tb/sim_nfb_net_builder.sv
module sim_nfb_net_builder;
    localparam int M  = 4;
    localparam int L  = 8;
    localparam int CW = 16;
    localparam int TW = 6;
    localparam int NS = M + 3;
    localparam int KW = $clog2(M);
    localparam int IW = $clog2(L);
    localparam int AW = $clog2(NS * L);
    localparam int OW = CW + 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 1'b0;
    logic [KW-1:0] k_i = '0;
    logic [TW-1:0] tc_i = '0;
    logic tbl_rd_o;
    logic [3:0][AW-1:0] tbl_addr_o;
    logic [3:0][CW-1:0] tbl_q_i = '0;
    logic coef_we_o;
    logic [IW-1:0] coef_addr_o;
    logic [OW-1:0] coef_o;
    logic done_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    logic signed [CW-1:0] mem [NS*L];

    always #4 clk = ~clk;   // 125 MHz

    nfb_net_builder #(.M(M), .L(L), .CW(CW), .TW(TW)) u0 (
        .clk(clk), .rst(rst), .start_i(start_i), .k_i(k_i), .tc_i(tc_i),
        .tbl_rd_o(tbl_rd_o), .tbl_addr_o(tbl_addr_o), .tbl_q_i(tbl_q_i),
        .coef_we_o(coef_we_o), .coef_addr_o(coef_addr_o), .coef_o(coef_o),
        .done_o(done_o)
    );

    // one-cycle synchronous table model
    always @(posedge clk)
        if (tbl_rd_o)
            for (int p = 0; p < 4; p++) tbl_q_i[p] <= mem[int'(tbl_addr_o[p])];

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    // R1 weight: which 0..3 = a..d
    function automatic longint wgt(input int which, input int t);
        longint s, t1, t2, t3, n, mag, q, d;
        s = longint'(1) << TW;
        t1 = t; t2 = t1 * t1; t3 = t2 * t1;
        case (which)
            0: n = -t3 + 3 * t2 * s - 2 * t1 * s * s;
            1: n = t3 - 2 * t2 * s - t1 * s * s + 2 * s * s * s;
            2: n = -t3 + t2 * s + 2 * t1 * s * s;
            default: n = t3 - t1 * s * s;
        endcase
        n = n * (longint'(1) << (30 - 3 * TW));
        d = (which == 0 || which == 3) ? 6 : 2;
        mag = (n < 0) ? -n : n;
        q = (mag + d / 2) / d;
        return (n < 0) ? -q : q;
    endfunction

    function automatic longint exp_coef(input int k, input int t, input int i);
        longint acc = 0;
        for (int p = 0; p < 4; p++)
            acc += wgt(p, t) * longint'(mem[(k + p) * L + i]);
        return (acc + (longint'(1) << 29)) >>> 30;
    endfunction

    task automatic fill_proto();
        for (int s = 0; s < NS; s++)
            for (int i = 0; i < L; i++)
                if (s < M) begin
                    int pidx = i * M + (M - 1 - s);
                    mem[s * L + i] = CW'(pidx * pidx * 2731 + pidx * 977 + 12345);
                end else begin
                    mem[s * L + i] = (i == 0) ? '0 : mem[(s - M) * L + i - 1];
                end
    endtask

    task automatic fill_const(input int v);
        for (int a = 0; a < NS * L; a++) mem[a] = CW'(v);
    endtask

    task automatic fill_extreme();
        for (int s = 0; s < NS; s++)
            for (int i = 0; i < L; i++)
                mem[s * L + i] = ((s + i) % 2 == 1) ? 16'sd32767 : -16'sd32768;
    endtask

    task automatic run(input int k, input int t, input bit poke, input string req);
        int rdn = 0;
        longint e;
        @(negedge clk);
        k_i = KW'(k); tc_i = TW'(t); start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int j = 0; j <= L + 2; j++) begin
            if (tbl_rd_o) rdn++;
            if (j >= 2 && j <= L + 1) begin
                int i = j - 2;
                e = exp_coef(k, t, i);
                chk(coef_we_o == 1'b1, "R3", longint'(coef_we_o), 1);
                chk(int'(coef_addr_o) == i, "R10", longint'(coef_addr_o), i);
                chk(longint'($signed(coef_o)) == e, req, longint'($signed(coef_o)), e);
                chk(done_o == (i == L - 1), "R4", longint'(done_o), longint'(i == L - 1));
            end
            if (j == L + 2) begin
                chk(coef_we_o == 1'b0, "R3", longint'(coef_we_o), 0);
                chk(done_o == 1'b0, "R4", longint'(done_o), 0);
                chk(rdn == L, "R9", rdn, L);
            end
            if (poke && j == 1) begin
                start_i = 1'b1; k_i = KW'((k + 2) % M); tc_i = TW'(t ^ 5);
            end
            if (poke && j == 2) start_i = 1'b0;
            if (j < L + 2) @(negedge clk);
        end
    endtask

    initial begin
        fill_proto();
        repeat (3) @(negedge clk);
        // R8: quiet during reset
        chk(coef_we_o == 1'b0, "R8", longint'(coef_we_o), 0);
        chk(done_o == 1'b0, "R8", longint'(done_o), 0);
        chk(tbl_rd_o == 1'b0, "R8", longint'(tbl_rd_o), 0);
        rst = 1'b0;
        @(negedge clk);
        // R1, R2 (top subfilters at k=M-1), R6 (tc=0)
        for (int k = 0; k < M; k++)
            for (int t = 0; t < (1 << TW); t++)
                run(k, t, 1'b0, (t == 0) ? "R6" : (k == M - 1) ? "R2" : "R1");
        // R7: start while busy is ignored
        run(1, 37, 1'b1, "R7");
        run(M - 1, 11, 1'b1, "R7");
        // R5: equal subfilters reproduce their value
        fill_const(12345);
        for (int t = 0; t < (1 << TW); t++) run(t % M, t, 1'b0, "R5");
        fill_const(-20000);
        for (int t = 0; t < (1 << TW); t += 3) run((t + 1) % M, t, 1'b0, "R5");
        // R1 at full-scale table words
        fill_extreme();
        for (int t = 0; t < (1 << TW); t += 5) run(t % M, t, 1'b0, "R1");
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule